// File: doc/BRIEF.md
# Panel Timing Generator with Active Window

This block drives a parallel RGB panel. It derives horizontal sync, vertical sync and data enable from two free-running counters. The first is a line counter that wraps once per line period. The second is a frame counter that counts every pixel clock of the whole frame. All vertical positions are given as absolute pixel-clock counts within the frame, so software can move the visible region by a sub-line skew simply by adding the skew to the vertical start and end values.

Inside the display region an optional active sub-window can be enabled. Pixels in the display region but outside that window receive a programmable border colour. Pixels inside the window are taken from a pixel input with a valid flag. When the source has no data, a programmable underflow colour replaces the pixel. A recovery option instead abandons the rest of the frame's window pixels until the next frame begins. Each of the three control outputs has its own polarity bit. A one-cycle frame-start pulse marks the first pixel clock of every frame and can serve as an interrupt source.

Register writes take effect at once, with no shadowing. All panel outputs are registered, so they follow the counter state by one clock.

Top module: `panel_timing_gen`

## Requirements
- R1: Address 0 bit 0 is the run control. While it is 0, both counters are held at 0, frame-start and data enable are inactive and rgb is 0. The clock edge that writes it to 1 starts the counters from 0 on the following cycle.
- R2: Address 1 holds the line period in bits [16+LINE_W-1:16] and the hsync width in its low bits. The line counter runs from 0 to period-1. Hsync is active while the line count is below the width. Every output appears one clock after the counter state it is decoded from.
- R3: Address 2 holds the frame length and address 3 the vsync width, both in pixel clocks. The frame counter runs from 0 to length-1, and vsync is active while the frame count is below the width.
- R4: Address 4 holds the horizontal display end in bits [31:16] and start in its low bits. Addresses 5 and 6 hold the vertical display start and end as frame counts. Data enable is active exactly when both counts lie within their inclusive ranges. Outside that region rgb is 0.
- R5: Address 7 holds the window end in bits [31:16], enable in bit 15 and start in its low bits. Address 8 holds the vertical window start with enable in bit 31, and address 9 holds the vertical window end. A disabled axis spans the whole display region. Display pixels outside the window show the border colour from address 10, with data enable still active.
- R6: Inside the window, pix_ready_o is high and, when pix_valid_i is high, rgb shows pix_rgb_i.
- R7: With recovery off (address 11 bit 31 clear), a window pixel with pix_valid_i low shows the underflow colour held in the low bits of address 11, for that cycle only.
- R8: With recovery on, an underflow makes every later window pixel of the same frame show the underflow colour with pix_ready_o low. Normal output resumes at the next frame's count 0.
- R9: Address 12 bits 0, 1 and 2 invert hsync, vsync and data enable respectively.
- R10: frame_start_o is high for the output cycle of frame count 0 while running.
- R11: After reset every output is 0 and every register reads as cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register address |
| cfg_wdata_i | input | 32 | Register write data |
| pix_valid_i | input | 1 | Pixel source has data this cycle |
| pix_rgb_i | input | RGB_W | Pixel colour from the source |
| pix_ready_o | output | 1 | Block consumes a pixel this cycle |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| rgb_o | output | RGB_W | Panel colour |
| frame_start_o | output | 1 | One-cycle frame start pulse |

## Verification
The main pattern is a full-window frame with the source always valid; it separates the sync and display decode from the pixel path. Enabling the window with a border colour separates border fill from pass-through. A periodic source gap is then run twice. With recovery off, the underflow colour must stay confined to the starved cycles. With recovery on, it must persist until frame count 0, which tells the two starvation modes apart. Inverted polarities, a stop and restart of the counters, and a display region shifted by a four-clock skew cover the remaining decode paths.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

   // register addresses of the write port
   typedef enum logic [3:0] {
      ADR_RUN    = 4'd0,
      ADR_LINE   = 4'd1,
      ADR_FRAME  = 4'd2,
      ADR_VSW    = 4'd3,
      ADR_HDISP  = 4'd4,
      ADR_VDS    = 4'd5,
      ADR_VDE    = 4'd6,
      ADR_HWIN   = 4'd7,
      ADR_VWS    = 4'd8,
      ADR_VWE    = 4'd9,
      ADR_BORDER = 4'd10,
      ADR_UFLOW  = 4'd11,
      ADR_POL    = 4'd12
   } ptg_addr_e;

   localparam int HI_LSB      = 16;  // upper half-word fields
   localparam int HWIN_EN_BIT = 15;
   localparam int VWIN_EN_BIT = 31;
   localparam int RECOV_BIT   = 31;

   // index of each control output in the polarity vector
   localparam int CTL_HS = 0;
   localparam int CTL_VS = 1;
   localparam int CTL_DE = 2;
   localparam int CTL_N  = 3;

endpackage

// File: rtl/ptg_regs.sv
module ptg_regs
   import ptg_pkg::*;
#(
   parameter int LINE_W  = 12,
   parameter int FRAME_W = 20,
   parameter int RGB_W   = 24
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               we_i,
   input  logic [3:0]         addr_i,
   input  logic [31:0]        wdata_i,
   output logic               run_o,
   output logic [LINE_W-1:0]  line_len_o,
   output logic [LINE_W-1:0]  hs_w_o,
   output logic [FRAME_W-1:0] frame_len_o,
   output logic [FRAME_W-1:0] vs_w_o,
   output logic [LINE_W-1:0]  hd_start_o,
   output logic [LINE_W-1:0]  hd_end_o,
   output logic [FRAME_W-1:0] vd_start_o,
   output logic [FRAME_W-1:0] vd_end_o,
   output logic               hw_en_o,
   output logic [LINE_W-1:0]  hw_start_o,
   output logic [LINE_W-1:0]  hw_end_o,
   output logic               vw_en_o,
   output logic [FRAME_W-1:0] vw_start_o,
   output logic [FRAME_W-1:0] vw_end_o,
   output logic [RGB_W-1:0]   border_o,
   output logic [RGB_W-1:0]   uf_rgb_o,
   output logic               uf_rec_o,
   output logic [CTL_N-1:0]   pol_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_o       <= 1'b0;
         line_len_o  <= '0;
         hs_w_o      <= '0;
         frame_len_o <= '0;
         vs_w_o      <= '0;
         hd_start_o  <= '0;
         hd_end_o    <= '0;
         vd_start_o  <= '0;
         vd_end_o    <= '0;
         hw_en_o     <= 1'b0;
         hw_start_o  <= '0;
         hw_end_o    <= '0;
         vw_en_o     <= 1'b0;
         vw_start_o  <= '0;
         vw_end_o    <= '0;
         border_o    <= '0;
         uf_rgb_o    <= '0;
         uf_rec_o    <= 1'b0;
         pol_o       <= '0;
      end else if (we_i) begin
         case (addr_i)
            ADR_RUN:    run_o <= wdata_i[0];
            ADR_LINE: begin
               line_len_o <= wdata_i[HI_LSB +: LINE_W];
               hs_w_o     <= wdata_i[LINE_W-1:0];
            end
            ADR_FRAME:  frame_len_o <= wdata_i[FRAME_W-1:0];
            ADR_VSW:    vs_w_o      <= wdata_i[FRAME_W-1:0];
            ADR_HDISP: begin
               hd_end_o   <= wdata_i[HI_LSB +: LINE_W];
               hd_start_o <= wdata_i[LINE_W-1:0];
            end
            ADR_VDS:    vd_start_o <= wdata_i[FRAME_W-1:0];
            ADR_VDE:    vd_end_o   <= wdata_i[FRAME_W-1:0];
            ADR_HWIN: begin
               hw_end_o   <= wdata_i[HI_LSB +: LINE_W];
               hw_en_o    <= wdata_i[HWIN_EN_BIT];
               hw_start_o <= wdata_i[LINE_W-1:0];
            end
            ADR_VWS: begin
               vw_en_o    <= wdata_i[VWIN_EN_BIT];
               vw_start_o <= wdata_i[FRAME_W-1:0];
            end
            ADR_VWE:    vw_end_o <= wdata_i[FRAME_W-1:0];
            ADR_BORDER: border_o <= wdata_i[RGB_W-1:0];
            ADR_UFLOW: begin
               uf_rec_o <= wdata_i[RECOV_BIT];
               uf_rgb_o <= wdata_i[RGB_W-1:0];
            end
            ADR_POL:    pol_o <= wdata_i[CTL_N-1:0];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/ptg_count.sv
module ptg_count #(
   parameter int LINE_W  = 12,
   parameter int FRAME_W = 20
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               run_i,
   input  logic [LINE_W-1:0]  line_len_i,
   input  logic [FRAME_W-1:0] frame_len_i,
   output logic [LINE_W-1:0]  hcnt_o,
   output logic [FRAME_W-1:0] fcnt_o,
   output logic               f_last_o
);

   logic h_last;

   // ">=" rather than "==" keeps the counters bounded if a length shrinks mid-run
   assign h_last   = hcnt_o >= (line_len_i - 1'b1);
   assign f_last_o = fcnt_o >= (frame_len_i - 1'b1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hcnt_o <= '0;
         fcnt_o <= '0;
      end else if (!run_i) begin
         hcnt_o <= '0;
         fcnt_o <= '0;
      end else begin
         hcnt_o <= h_last   ? '0 : hcnt_o + 1'b1;
         fcnt_o <= f_last_o ? '0 : fcnt_o + 1'b1;
      end
   end

   // R1: a stopped generator restarts from count 0
   p_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (hcnt_o == '0 && fcnt_o == '0));

   // R3: a non-zero frame count always comes from a single-step advance
   p_fstep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && $past(run_i) && fcnt_o != '0) |-> fcnt_o == $past(fcnt_o) + 1'b1);

endmodule

// File: rtl/ptg_pixel.sv
module ptg_pixel
   import ptg_pkg::*;
#(
   parameter int LINE_W  = 12,
   parameter int FRAME_W = 20,
   parameter int RGB_W   = 24
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               run_i,
   input  logic [LINE_W-1:0]  hcnt_i,
   input  logic [FRAME_W-1:0] fcnt_i,
   input  logic               f_last_i,
   input  logic [LINE_W-1:0]  hs_w_i,
   input  logic [FRAME_W-1:0] vs_w_i,
   input  logic [LINE_W-1:0]  hd_start_i,
   input  logic [LINE_W-1:0]  hd_end_i,
   input  logic [FRAME_W-1:0] vd_start_i,
   input  logic [FRAME_W-1:0] vd_end_i,
   input  logic               hw_en_i,
   input  logic [LINE_W-1:0]  hw_start_i,
   input  logic [LINE_W-1:0]  hw_end_i,
   input  logic               vw_en_i,
   input  logic [FRAME_W-1:0] vw_start_i,
   input  logic [FRAME_W-1:0] vw_end_i,
   input  logic [RGB_W-1:0]   border_i,
   input  logic [RGB_W-1:0]   uf_rgb_i,
   input  logic               uf_rec_i,
   input  logic [CTL_N-1:0]   pol_i,
   input  logic               pix_valid_i,
   input  logic [RGB_W-1:0]   pix_rgb_i,
   output logic               pix_ready_o,
   output logic               hsync_o,
   output logic               vsync_o,
   output logic               de_o,
   output logic [RGB_W-1:0]   rgb_o,
   output logic               frame_start_o
);

   logic             in_hd, in_vd, disp, in_hw, in_vw, win, take, starve;
   logic             drop_q, drop_n;
   logic [CTL_N-1:0] ctl_raw, ctl_q;
   logic [RGB_W-1:0] rgb_n, rgb_q;
   logic             fs_q;

   // region decode on the live counts
   assign in_hd = (hcnt_i >= hd_start_i) && (hcnt_i <= hd_end_i);
   assign in_vd = (fcnt_i >= vd_start_i) && (fcnt_i <= vd_end_i);
   assign disp  = run_i && in_hd && in_vd;
   assign in_hw = !hw_en_i || ((hcnt_i >= hw_start_i) && (hcnt_i <= hw_end_i));
   assign in_vw = !vw_en_i || ((fcnt_i >= vw_start_i) && (fcnt_i <= vw_end_i));
   assign win   = in_hw && in_vw;
   assign take  = disp && win;

   assign pix_ready_o = take && !drop_q;
   assign starve      = pix_ready_o && !pix_valid_i;

   assign ctl_raw[CTL_HS] = run_i && (hcnt_i < hs_w_i);
   assign ctl_raw[CTL_VS] = run_i && (fcnt_i < vs_w_i);
   assign ctl_raw[CTL_DE] = disp;

   always_comb begin
      if (!disp)                     rgb_n = '0;
      else if (!win)                 rgb_n = border_i;
      else if (drop_q || !pix_valid_i) rgb_n = uf_rgb_i;
      else                           rgb_n = pix_rgb_i;
   end

   // frame-drop state for recovery mode; frame end wins over a new underflow
   always_comb begin
      drop_n = drop_q;
      if (!run_i || f_last_i)   drop_n = 1'b0;
      else if (starve && uf_rec_i) drop_n = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         drop_q <= 1'b0;
         rgb_q  <= '0;
         fs_q   <= 1'b0;
      end else begin
         drop_q <= drop_n;
         rgb_q  <= rgb_n;
         fs_q   <= run_i && (fcnt_i == '0);
      end
   end

   // one polarity stage per control output
   for (genvar g = 0; g < CTL_N; g++) begin : g_pol
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) ctl_q[g] <= 1'b0;
         else         ctl_q[g] <= ctl_raw[g] ^ pol_i[g];
      end
   end

   assign hsync_o       = ctl_q[CTL_HS];
   assign vsync_o       = ctl_q[CTL_VS];
   assign de_o          = ctl_q[CTL_DE];
   assign rgb_o         = rgb_q;
   assign frame_start_o = fs_q;

   // R4: colour is blank whenever the previous cycle was outside the display region
   p_blank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(disp) |-> rgb_q == '0);

   // R1: no frame start while the counters were held
   p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(run_i) |-> !fs_q);

   // R8: the drop state never survives into a new frame
   p_drop_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && fcnt_i == '0) |-> !drop_q);

   // R6: a consumed pixel is always followed by data enable in its active level
   p_ready_de_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pix_ready_o && $stable(pol_i)) |=> (de_o != pol_i[CTL_DE]));

endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
   import ptg_pkg::*;
#(
   parameter int LINE_W  = 12,
   parameter int FRAME_W = 20,
   parameter int RGB_W   = 24
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cfg_we_i,
   input  logic [3:0]       cfg_addr_i,
   input  logic [31:0]      cfg_wdata_i,
   input  logic             pix_valid_i,
   input  logic [RGB_W-1:0] pix_rgb_i,
   output logic             pix_ready_o,
   output logic             hsync_o,
   output logic             vsync_o,
   output logic             de_o,
   output logic [RGB_W-1:0] rgb_o,
   output logic             frame_start_o
);

   initial begin
      assert (LINE_W >= 2 && LINE_W <= HWIN_EN_BIT)
         else $error("LINE_W must fit below the window enable bit");
      assert (FRAME_W >= 2 && FRAME_W < VWIN_EN_BIT)
         else $error("FRAME_W must fit below the vertical enable bit");
      assert (RGB_W >= 1 && RGB_W < RECOV_BIT)
         else $error("RGB_W must fit below the recovery bit");
   end

   logic               run;
   logic [LINE_W-1:0]  line_len, hs_w, hd_start, hd_end, hw_start, hw_end, hcnt;
   logic [FRAME_W-1:0] frame_len, vs_w, vd_start, vd_end, vw_start, vw_end, fcnt;
   logic               hw_en, vw_en, uf_rec, f_last;
   logic [RGB_W-1:0]   border, uf_rgb;
   logic [CTL_N-1:0]   pol;

   ptg_regs #(.LINE_W(LINE_W), .FRAME_W(FRAME_W), .RGB_W(RGB_W)) u_regs (
      .clk_i, .rst_ni,
      .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
      .run_o(run), .line_len_o(line_len), .hs_w_o(hs_w),
      .frame_len_o(frame_len), .vs_w_o(vs_w),
      .hd_start_o(hd_start), .hd_end_o(hd_end),
      .vd_start_o(vd_start), .vd_end_o(vd_end),
      .hw_en_o(hw_en), .hw_start_o(hw_start), .hw_end_o(hw_end),
      .vw_en_o(vw_en), .vw_start_o(vw_start), .vw_end_o(vw_end),
      .border_o(border), .uf_rgb_o(uf_rgb), .uf_rec_o(uf_rec), .pol_o(pol)
   );

   ptg_count #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_count (
      .clk_i, .rst_ni, .run_i(run),
      .line_len_i(line_len), .frame_len_i(frame_len),
      .hcnt_o(hcnt), .fcnt_o(fcnt), .f_last_o(f_last)
   );

   ptg_pixel #(.LINE_W(LINE_W), .FRAME_W(FRAME_W), .RGB_W(RGB_W)) u_pixel (
      .clk_i, .rst_ni, .run_i(run),
      .hcnt_i(hcnt), .fcnt_i(fcnt), .f_last_i(f_last),
      .hs_w_i(hs_w), .vs_w_i(vs_w),
      .hd_start_i(hd_start), .hd_end_i(hd_end),
      .vd_start_i(vd_start), .vd_end_i(vd_end),
      .hw_en_i(hw_en), .hw_start_i(hw_start), .hw_end_i(hw_end),
      .vw_en_i(vw_en), .vw_start_i(vw_start), .vw_end_i(vw_end),
      .border_i(border), .uf_rgb_i(uf_rgb), .uf_rec_i(uf_rec), .pol_i(pol),
      .pix_valid_i, .pix_rgb_i, .pix_ready_o,
      .hsync_o, .vsync_o, .de_o, .rgb_o, .frame_start_o
   );

endmodule

// File: tb/panel_timing_gen_bench.sv
module panel_timing_gen_bench;

   localparam int LW = 12;
   localparam int FW = 20;
   localparam int CW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          we = 1'b0;
   logic [3:0]    wa = '0;
   logic [31:0]   wd = '0;
   logic          pv = 1'b0;
   logic [CW-1:0] pd = '0;
   logic          ready, hs, vs, de, fs;
   logic [CW-1:0] rgb;

   always #10 clk = ~clk;

   panel_timing_gen #(.LINE_W(LW), .FRAME_W(FW), .RGB_W(CW)) u_panel_timing_gen (
      .clk_i(clk), .rst_ni(rst_n),
      .cfg_we_i(we), .cfg_addr_i(wa), .cfg_wdata_i(wd),
      .pix_valid_i(pv), .pix_rgb_i(pd), .pix_ready_o(ready),
      .hsync_o(hs), .vsync_o(vs), .de_o(de), .rgb_o(rgb), .frame_start_o(fs)
   );

   // ---------------- reference model ----------------
   logic [31:0]   rg [0:15];
   int            m_h = 0, m_f = 0;
   bit            m_run = 0, m_drop = 0;
   logic          e_hs = 0, e_vs = 0, e_de = 0, e_fs = 0;
   logic [CW-1:0] e_rgb = '0;
   bit            md, mw;
   int            n_chk = 0, n_err = 0, cyc = 0, gap_mode = 0;
   bit            started = 0, done = 0;

   initial for (int i = 0; i < 16; i++) rg[i] = '0;

   function automatic bit in_rng(int v, int lo, int hi);
      return v >= lo && v <= hi;
   endfunction

   function automatic bit f_disp(int h, int f);
      return m_run && in_rng(h, int'(rg[4][LW-1:0]), int'(rg[4][16 +: LW]))
                   && in_rng(f, int'(rg[5][FW-1:0]), int'(rg[6][FW-1:0]));
   endfunction

   function automatic bit f_win(int h, int f);
      bit okh, okv;
      okh = !rg[7][15] || in_rng(h, int'(rg[7][LW-1:0]), int'(rg[7][16 +: LW]));
      okv = !rg[8][31] || in_rng(f, int'(rg[8][FW-1:0]), int'(rg[9][FW-1:0]));
      return okh && okv;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_h = 0; m_f = 0; m_run = 0; m_drop = 0;
         e_hs = 0; e_vs = 0; e_de = 0; e_fs = 0; e_rgb = '0;
         for (int i = 0; i < 16; i++) rg[i] = '0;
      end else begin
         md = f_disp(m_h, m_f);
         mw = f_win(m_h, m_f);
         e_hs = (m_run && m_h < int'(rg[1][LW-1:0])) ^ rg[12][0];
         e_vs = (m_run && m_f < int'(rg[3][FW-1:0])) ^ rg[12][1];
         e_de = md ^ rg[12][2];
         e_fs = m_run && m_f == 0;
         if (!md)               e_rgb = '0;
         else if (!mw)          e_rgb = rg[10][CW-1:0];
         else if (m_drop || !pv) e_rgb = rg[11][CW-1:0];
         else                   e_rgb = pd;
         if (!m_run) begin
            m_h = 0; m_f = 0; m_drop = 0;
         end else begin
            if (m_f >= int'(rg[2][FW-1:0]) - 1) m_drop = 0;
            else if (md && mw && !m_drop && !pv && rg[11][31]) m_drop = 1;
            m_h = (m_h >= int'(rg[1][16 +: LW]) - 1) ? 0 : m_h + 1;
            m_f = (m_f >= int'(rg[2][FW-1:0]) - 1) ? 0 : m_f + 1;
         end
         if (we) rg[wa] = wd;
         m_run = rg[0][0];
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare away from the active edge, every cycle
   always @(negedge clk) begin
      if (started && !done) begin
         chk(32'(hs),  32'(e_hs),  "R2 R9 R11 hsync");
         chk(32'(vs),  32'(e_vs),  "R3 R9 R11 vsync");
         chk(32'(de),  32'(e_de),  "R4 R5 R9 R11 de");
         chk(32'(fs),  32'(e_fs),  "R10 R1 frame_start");
         chk(32'(rgb), 32'(e_rgb), "R4 R5 R6 R7 R8 rgb");
         chk(32'(ready), 32'(f_disp(m_h, m_f) && f_win(m_h, m_f) && !m_drop), "R6 R8 ready");
      end
   end

   // pixel source: data follows the cycle count, gaps on demand
   always @(negedge clk) begin
      cyc++;
      pd = {8'h3C, 16'(cyc)};
      pv = (gap_mode == 0) ? 1'b1 : ((cyc % 7) != 3);
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; wa = a; wd = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      @(posedge clk);
      started = 1;
      run(4);                       // R11: reset state
      rst_n = 1'b1;
      run(3);
      // 20-clock lines, 10-line frame, display x 5..16, frame counts 60..179
      wr(4'd1, 32'h0014_0002);      // R2
      wr(4'd2, 32'd200);            // R3
      wr(4'd3, 32'd20);
      wr(4'd4, 32'h0010_0005);      // R4
      wr(4'd5, 32'd60);
      wr(4'd6, 32'd179);
      wr(4'd10, 32'h0000_FF00);
      wr(4'd11, 32'h00FF_0000);
      wr(4'd0, 32'd1);              // R1 start
      run(450);                     // R6 R10 full window, always valid
      wr(4'd7, 32'h000C_8007);      // R5 window x 7..12
      wr(4'd8, 32'h8000_0050);      // R5 window counts 80..139
      wr(4'd9, 32'd139);
      run(450);
      gap_mode = 1;                 // R7 underflow, no recovery
      run(450);
      wr(4'd11, 32'h80FF_0000);     // R8 recovery on
      run(450);
      gap_mode = 0;
      wr(4'd12, 32'd7);             // R9 all inverted
      run(250);
      wr(4'd12, 32'd0);
      wr(4'd0, 32'd0);              // R1 stop
      run(50);
      wr(4'd5, 32'd64);             // skewed display region
      wr(4'd6, 32'd183);
      wr(4'd8, 32'h8000_0054);
      wr(4'd9, 32'd143);
      wr(4'd0, 32'd1);              // R1 restart from 0
      run(450);
      finish_run();
   end

endmodule